// File: doc/BRIEF.md
# Guard Time Monitor for a Smart Card Serial Line

This block watches the single bidirectional data line of a smart card interface and measures how many elementary time units (ETUs) have gone by since the most recent start bit. Every start bit on the line restarts the measurement. It does not matter whether the reader or the card sent the character. When the required guard interval has elapsed with no new start bit, the block raises a flag that a status register can expose.

The guard interval depends on the transmission protocol. With the block-oriented protocol (T=1) it is 22 ETU. With the character-oriented protocol (T=0) it is 16 ETU. The protocol select is sampled only when a start bit is recognised, so a change takes effect at the next character. The ETU tick comes from an external baud generator as a one-cycle pulse. The line is brought into the clock domain through a synchroniser chain before start bits are detected.

The control is a three-state machine:
- `ST_IDLE`: after reset, no start bit has been seen yet.
- `ST_TIMING`: ticks are being counted.
- `ST_ELAPSED`: the guard interval has completed and the counter is saturated.

It has two named transitions:
- `START`: from any state to `ST_TIMING` when a start bit is recognised.
- `EXPIRE`: from `ST_TIMING` to `ST_ELAPSED` on the tick that completes the interval.

Top module: `guard_time_monitor`

## Requirements
- R1: After reset the flag `guard_elapsed_o` is 0 and the machine is in `ST_IDLE`.
- R2: A start bit is a high-to-low transition of the synchronised line. It is recognised, and the flag is cleared, on the third rising clock edge after `io_line_i` falls, with the default two synchroniser stages.
- R3: With `proto_t1_i` = 1 at the start bit, the flag rises on the clock edge that samples the 22nd ETU tick after the start bit. It stays 0 after 21 ticks.
- R4: With `proto_t1_i` = 0 at the start bit, the flag rises on the edge that samples the 16th ETU tick after the start bit. It stays 0 after 15 ticks.
- R5: Once set, the flag stays 1 under any number of further ticks until the next start bit. The counter saturates at the terminal count.
- R6: When a start bit and an ETU tick fall in the same cycle, the start bit wins. The count reloads to zero, that tick is not counted and the flag is 0 in the next cycle.
- R7: Changing `proto_t1_i` during a count does not alter the interval being measured. The new selection applies from the next start bit.
- R8: ETU ticks before the first start bit after reset leave the flag at 0.
- R9: A start bit arriving before the interval completes restarts the count from zero. The flag therefore does not rise at the time the earlier count would have ended.
- R10: A rising edge of the line, or a line held low, is not a start bit and leaves the flag and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| etu_tick_i | input | 1 | One-cycle pulse per elementary time unit |
| io_line_i | input | 1 | Asynchronous level of the card data line, idle high |
| proto_t1_i | input | 1 | Protocol select: 1 = T=1 (22 ETU), 0 = T=0 (16 ETU) |
| guard_elapsed_o | output | 1 | Guard interval elapsed since the last start bit |

## Verification
Restarting on a start bit and counting a tick can fall in the same cycle. This includes the tick that would complete the interval while the flag is already set. The bench provokes the collision by placing a tick exactly in the third cycle after the line falls. It then judges the result by requiring a full 16 or 22 further ticks before the flag rises again. Random traffic with frequent ticks and occasional line toggles produces many more such collisions. These are checked every cycle against a cycle-level reference model in the bench.

// File: rtl/gtm_pkg.sv
package gtm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TIMING  = 2'd1,
        ST_ELAPSED = 2'd2
    } gtm_state_e;

endpackage

// File: rtl/gtm_line_sync.sv
module gtm_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic start_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[0] <= 1'b1;
                else         chain_q[0] <= line_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[g] <= 1'b1;
                else         chain_q[g] <= chain_q[g-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= 1'b1;
        else         last_q <= chain_q[SYNC_STAGES-1];
    end

    assign start_o = last_q & ~chain_q[SYNC_STAGES-1];

    // R10: a start needs the line to have been high in the previous cycle
    a_r10_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);
endmodule

// File: rtl/gtm_etu_counter.sv
module gtm_etu_counter #(
    parameter int GUARD_T0 = 16,
    parameter int GUARD_T1 = 22,
    parameter int CNT_W    = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             proto_t1_i,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LIM_T0 = CNT_W'(GUARD_T0);
    localparam logic [CNT_W-1:0] LIM_T1 = CNT_W'(GUARD_T1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic             step_w;

    assign step_w = run_i & tick_i & ~start_i & (cnt_q != lim_q);
    assign done_o = step_w & (cnt_q == lim_q - CNT_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            lim_q <= LIM_T0;
        end else if (start_i) begin
            cnt_q <= '0;
            lim_q <= proto_t1_i ? LIM_T1 : LIM_T0;
        end else if (step_w) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R5: count saturates at the latched terminal value
    a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= lim_q);
    // R6: start wins over a tick in the same cycle
    a_r6_start_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> cnt_q == '0);
    // R7: the limit changes only at a start bit
    a_r7_limit_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable(lim_q));
    // R10: no start and no tick leaves the count alone
    a_r10_count_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/gtm_guard_fsm.sv
module gtm_guard_fsm
    import gtm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic done_i,
    output logic run_o,
    output logic elapsed_o
);
    gtm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_TIMING;
            ST_TIMING:  if (start_i) state_d = ST_TIMING;
                        else if (done_i) state_d = ST_ELAPSED;
            ST_ELAPSED: if (start_i) state_d = ST_TIMING;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        run_o     = (state_q == ST_TIMING);
        elapsed_o = (state_q == ST_ELAPSED);
    end

    // R8: idle persists without a start bit
    a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/guard_time_monitor.sv
module guard_time_monitor #(
    parameter int GUARD_T0    = 16,
    parameter int GUARD_T1    = 22,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic etu_tick_i,
    input  logic io_line_i,
    input  logic proto_t1_i,
    output logic guard_elapsed_o
);
    localparam int MAX_GUARD = (GUARD_T1 > GUARD_T0) ? GUARD_T1 : GUARD_T0;
    localparam int CNT_W     = $clog2(MAX_GUARD + 1);

    logic start_w;
    logic run_w;
    logic done_w;

    gtm_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .line_i  (io_line_i),
        .start_o (start_w)
    );

    gtm_etu_counter #(.GUARD_T0(GUARD_T0), .GUARD_T1(GUARD_T1), .CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_w),
        .run_i      (run_w),
        .tick_i     (etu_tick_i),
        .proto_t1_i (proto_t1_i),
        .done_o     (done_w)
    );

    gtm_guard_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_w),
        .done_i    (done_w),
        .run_o     (run_w),
        .elapsed_o (guard_elapsed_o)
    );

    // R2: a start bit clears the flag in the next cycle
    a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_w |=> !guard_elapsed_o);
    // R5: flag holds until a start bit
    a_r5_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (guard_elapsed_o && !start_w) |=> guard_elapsed_o);
    // R3: the flag only rises on a sampled tick
    a_r3_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(guard_elapsed_o) |-> $past(etu_tick_i));
endmodule

// File: tb/guard_time_monitor_tb.sv
module guard_time_monitor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic io = 1'b1;
    logic proto = 1'b0;
    logic flag;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    logic m_s1, m_s2, m_s3, m_run, m_flag;
    int   m_cnt, m_lim;

    always #10 clk = ~clk;

    guard_time_monitor dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .etu_tick_i      (tick),
        .io_line_i       (io),
        .proto_t1_i      (proto),
        .guard_elapsed_o (flag)
    );

    function automatic int guard_len(input logic t1);
        return t1 ? 22 : 16;
    endfunction

    // cycle-level reference model from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_s3 <= 1'b1;
            m_run <= 1'b0; m_flag <= 1'b0; m_cnt <= 0; m_lim <= 16;
        end else begin
            m_s1 <= io; m_s2 <= m_s1; m_s3 <= m_s2;
            if (m_s3 && !m_s2) begin
                m_cnt <= 0; m_lim <= guard_len(proto); m_run <= 1'b1; m_flag <= 1'b0;
            end else if (m_run && !m_flag && tick) begin
                m_cnt <= m_cnt + 1;
                if (m_cnt + 1 == m_lim) m_flag <= 1'b1;
            end
        end
    end

    task automatic check(input string tag, input logic exp);
        checks++;
        if (flag !== exp) begin
            failures++;
            $display("FAIL %s: flag=%0b expected=%0b", tag, flag, exp);
        end
    endtask

    task automatic step(input logic l, input logic t);
        io = l; tick = t;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(io, 1'b1);
        tick = 1'b0;
    endtask

    task automatic fall_start();
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        @(negedge clk); @(negedge clk);
        check("R1 reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b0);

        ticks(30);
        check("R8 ticks before first start", 1'b0);

        proto = 1'b1;
        fall_start();
        ticks(21);
        check("R3 T1 after 21 ticks", 1'b0);
        ticks(1);
        check("R3 T1 after 22 ticks", 1'b1);
        ticks(40);
        check("R5 saturated hold", 1'b1);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        check("R10 rising edge ignored", 1'b1);

        proto = 1'b0;
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        check("R2 not yet recognised", 1'b1);
        step(1'b0, 1'b0);
        check("R2 cleared on third edge", 1'b0);
        ticks(15);
        check("R4 T0 after 15 ticks", 1'b0);
        ticks(1);
        check("R4 T0 after 16 ticks", 1'b1);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
        check("R10 line held low", 1'b1);

        fall_start();
        ticks(10);
        fall_start();
        ticks(10);
        check("R9 restart before completion", 1'b0);
        ticks(5);
        check("R9 15 ticks after restart", 1'b0);
        ticks(1);
        check("R9 16 ticks after restart", 1'b1);

        proto = 1'b0;
        fall_start();
        proto = 1'b1;
        ticks(16);
        check("R7 T0 kept after switch to T1", 1'b1);
        proto = 1'b1;
        fall_start();
        proto = 1'b0;
        ticks(16);
        check("R7 T1 kept after switch to T0", 1'b0);
        ticks(6);
        check("R7 T1 completes at 22", 1'b1);

        proto = 1'b0;
        step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b1); step(1'b0, 1'b1);
        tick = 1'b0;
        check("R6 start with tick clears flag", 1'b0);
        ticks(15);
        check("R6 coincident tick not counted", 1'b0);
        ticks(1);
        check("R6 full interval after collision", 1'b1);

        for (int i = 0; i < 6000; i++) begin
            logic nl, nt;
            nl = (($urandom % 30) == 0) ? ~io : io;
            nt = (($urandom % 2) == 0);
            if (($urandom % 60) == 0) proto = ~proto;
            step(nl, nt);
            check("R3 random vs model", m_flag);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule